// File: doc/BRIEF.md
# Regulator Short-Circuit Protection Sequencer

This block watches a set of regulator rails and decides, rail by rail, when an output counts as shorted or overloaded. Each rail has a software enable request, a digital "output below threshold" flag from an external comparator, and a shared time-base tick. A rail turns on when its enable request rises. A millisecond is expressed as a parameterized number of ticks.

Two checks run on each rail. The start-up check looks at the comparator once, one millisecond after the rail turns on. If the output is still low at that moment, the rail has a short. Once the rail passes that check, the overload check runs continuously. The output must stay low for an unbroken millisecond before the rail counts as overloaded. Either failure turns off only that rail and sends a one-cycle event to the interrupt logic. The rail then stays off until software clears the fault and raises the enable again.

A global shutdown input carries a thermal or over-voltage condition. It turns every rail off at once and holds the general-purpose outputs low while it is asserted.

Top module: `scp_sequencer`

## Requirements
- R1: While reset is high and in the first cycle after it, every rail_on bit, every sc_event bit and gpo_force_low are 0.
- R2: A rail in the off state turns on (its rail_on bit becomes 1) at the first clock edge where its rail_en_req bit is 1, if that bit was 0 at the previous edge and glb_shutdown is 0.
- R3: At the MS_TICKS-th tick after a rail turns on, the rail's out_low bit decides the outcome. If out_low is 1, the rail turns off and its sc_event bit is 1 for that cycle. If out_low is 0, the rail stays on and raises no event.
- R4: A value of 1 on out_low before the MS_TICKS-th start-up tick has no effect. The rail stays on and raises no event.
- R5: After the start-up check passes, a rail turns off and pulses its sc_event bit when out_low has been 1 through MS_TICKS consecutive ticks.
- R6: A cycle with out_low at 0 during operation restarts the overload count, so MS_TICKS fresh ticks are needed again.
- R7: A fault turns off only its own rail and raises only its own sc_event bit.
- R8: A faulted rail stays off, even with its enable request held high or raised again, until its fault_clr bit is pulsed. After the clear, a new rising enable restarts the start-up check.
- R9: When rail_en_req goes to 0, the rail turns off at the next edge and raises no event.
- R10: While glb_shutdown is 1, every rail is off from the next edge on, no sc_event is raised, and gpo_force_low is 1 one edge later. After release, gpo_force_low returns to 0 and a rail needs a new rising enable to turn on.
- R11: Each sc_event pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base pulse, MS_TICKS of them per millisecond |
| rail_en_req | input | NUM_RAILS | Per-rail enable request from software |
| out_low | input | NUM_RAILS | Per-rail comparator flag: output below threshold |
| fault_clr | input | NUM_RAILS | Per-rail pulse that releases a latched fault |
| glb_shutdown | input | 1 | Thermal or over-voltage shutdown, forces all rails off |
| rail_on | output | NUM_RAILS | Registered per-rail enable command |
| sc_event | output | NUM_RAILS | One-cycle short or overload event per rail |
| gpo_force_low | output | 1 | Registered command holding the general-purpose outputs low |

## Verification
Every output is registered. A change on an input appears one clock edge later, and a fault appears at the same edge that takes in the deciding MS_TICKS-th tick. The bench applies each stimulus just after a falling edge and samples at the next falling edge. That way it reads the result of exactly one rising edge. Ticks are sent one at a time, so the bench can confirm that nothing happens after MS_TICKS-1 ticks and that the fault appears after the next one. The bench also checks that the event is gone one cycle after it appears.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    RAIL_OFF   = 2'd0,
    RAIL_START = 2'd1,
    RAIL_RUN   = 2'd2,
    RAIL_FAULT = 2'd3
  } rail_state_e;
endpackage

// File: rtl/scp_win_cnt.sv
// Tick counter used for both the start-up window and the overload debounce.
module scp_win_cnt #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (inc && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_VAL);

  // R6: the count never runs past the window
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_VAL);
endmodule

// File: rtl/scp_rail_fsm.sv
// One rail: start-up short check, running overload debounce, fault latch.
module scp_rail_fsm
  import scp_pkg::*;
#(
  parameter int MS_TICKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic en_req,
  input  logic below,
  input  logic fault_clr,
  input  logic shut,
  output logic rail_on,
  output logic sc_event
);
  rail_state_e state, nxt;
  logic en_prev, win_last, win_clr, win_inc, fire;

  scp_win_cnt #(.LIMIT(MS_TICKS)) u_win (
    .clk  (clk),
    .rst  (rst),
    .clr  (win_clr),
    .inc  (win_inc),
    .last (win_last)
  );

  always_comb begin
    nxt  = state;
    fire = 1'b0;
    unique case (state)
      RAIL_OFF: begin
        if (en_req && !en_prev && !shut) nxt = RAIL_START;
      end
      RAIL_START: begin
        if (shut || !en_req) nxt = RAIL_OFF;
        else if (tick && win_last) begin
          if (below) begin
            nxt  = RAIL_FAULT;
            fire = 1'b1;
          end else begin
            nxt = RAIL_RUN;
          end
        end
      end
      RAIL_RUN: begin
        if (shut || !en_req) nxt = RAIL_OFF;
        else if (below && tick && win_last) begin
          nxt  = RAIL_FAULT;
          fire = 1'b1;
        end
      end
      RAIL_FAULT: begin
        if (fault_clr) nxt = RAIL_OFF;
      end
      default: nxt = RAIL_OFF;
    endcase
  end

  // Counter restarts on any state change, when idle, and whenever the
  // running output is seen above threshold.
  assign win_clr = (nxt != state) || (state == RAIL_OFF) || (state == RAIL_FAULT)
                 || (state == RAIL_RUN && !below);
  assign win_inc = tick && (state == RAIL_START || state == RAIL_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RAIL_OFF;
      en_prev  <= 1'b0;
      rail_on  <= 1'b0;
      sc_event <= 1'b0;
    end else begin
      state    <= nxt;
      en_prev  <= en_req;
      rail_on  <= (nxt == RAIL_START) || (nxt == RAIL_RUN);
      sc_event <= fire;
    end
  end

  p_event_drops_rail_r3: assert property (@(posedge clk) disable iff (rst)
    sc_event |-> (!rail_on && $past(rail_on)));

  p_event_single_r11: assert property (@(posedge clk) disable iff (rst)
    sc_event |=> !sc_event);

  p_shut_all_off_r10: assert property (@(posedge clk) disable iff (rst)
    shut |=> (!rail_on && !sc_event));

  p_fault_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (state == RAIL_FAULT && !fault_clr) |=> (!rail_on && state == RAIL_FAULT));

  p_disable_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en_req |=> (!rail_on && !sc_event));

  p_start_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rail_on) |-> ($past(en_req) && !$past(shut)));
endmodule

// File: rtl/scp_sequencer.sv
module scp_sequencer #(
  parameter int NUM_RAILS = 4,
  parameter int MS_TICKS  = 1000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [NUM_RAILS-1:0] rail_en_req,
  input  logic [NUM_RAILS-1:0] out_low,
  input  logic [NUM_RAILS-1:0] fault_clr,
  input  logic                 glb_shutdown,
  output logic [NUM_RAILS-1:0] rail_on,
  output logic [NUM_RAILS-1:0] sc_event,
  output logic                 gpo_force_low
);
  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    scp_rail_fsm #(.MS_TICKS(MS_TICKS)) u_rail (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .en_req    (rail_en_req[g]),
      .below     (out_low[g]),
      .fault_clr (fault_clr[g]),
      .shut      (glb_shutdown),
      .rail_on   (rail_on[g]),
      .sc_event  (sc_event[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) gpo_force_low <= 1'b0;
    else     gpo_force_low <= glb_shutdown;
  end

  p_gpo_set_r10: assert property (@(posedge clk) disable iff (rst)
    glb_shutdown |=> gpo_force_low);

  p_gpo_clear_r10: assert property (@(posedge clk) disable iff (rst)
    !glb_shutdown |=> !gpo_force_low);

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (rail_on == '0 && sc_event == '0 && !gpo_force_low));
endmodule

// File: tb/tb_scp_sequencer.sv
module tb_scp_sequencer;
  localparam int N  = 3;
  localparam int MS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic shut = 1'b0;
  logic [N-1:0] en = '0, below = '0, clr = '0;
  logic [N-1:0] rail_on, sc_event;
  logic gpo_low;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scp_sequencer #(.NUM_RAILS(N), .MS_TICKS(MS)) dut (
    .clk(clk), .rst(rst), .tick(tick), .rail_en_req(en), .out_low(below),
    .fault_clr(clr), .glb_shutdown(shut), .rail_on(rail_on),
    .sc_event(sc_event), .gpo_force_low(gpo_low)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    cyc();
    tick = 1'b0;
  endtask

  task automatic rise(input int i);
    en[i] = 1'b0;
    cyc();
    en[i] = 1'b1;
    cyc();
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    check("R1 rail_on in reset", 32'(rail_on), 0);
    rst = 1'b0;
    cyc();
    check("R1 rail_on", 32'(rail_on), 0);
    check("R1 sc_event", 32'(sc_event), 0);
    check("R1 gpo", 32'(gpo_low), 0);
  endtask

  task automatic t_startup_short();
    below[0] = 1'b1;
    rise(0);
    check("R2 rail0 on", 32'(rail_on), 3'b001);
    repeat (MS - 1) pulse_tick();
    check("R4 early low ignored", 32'(rail_on), 3'b001);
    check("R4 no early event", 32'(sc_event), 0);
    pulse_tick();
    check("R3 short turns off", 32'(rail_on), 0);
    check("R3 R7 event rail0 only", 32'(sc_event), 3'b001);
    cyc();
    check("R11 event one cycle", 32'(sc_event), 0);
  endtask

  task automatic t_fault_latch();
    rise(0);
    check("R8 stays off on new enable", 32'(rail_on), 0);
    clr[0] = 1'b1;
    cyc();
    clr[0] = 1'b0;
    cyc();
    check("R8 clear alone does not enable", 32'(rail_on), 0);
    below[0] = 1'b0;
    rise(0);
    check("R8 new enable restarts", 32'(rail_on), 3'b001);
    repeat (MS) pulse_tick();
    check("R3 good start stays on", 32'(rail_on), 3'b001);
    check("R3 good start no event", 32'(sc_event), 0);
  endtask

  task automatic t_overload();
    rise(1);
    repeat (MS) pulse_tick();
    check("R3 rail1 running", 32'(rail_on), 3'b011);
    below[0] = 1'b1;
    repeat (MS - 1) pulse_tick();
    below[0] = 1'b0;
    cyc();
    below[0] = 1'b1;
    repeat (MS - 1) pulse_tick();
    check("R6 debounce restarted", 32'(rail_on), 3'b011);
    check("R6 no event yet", 32'(sc_event), 0);
    pulse_tick();
    check("R5 R7 overload only rail0", 32'(rail_on), 3'b010);
    check("R5 event rail0", 32'(sc_event), 3'b001);
    cyc();
    check("R11 overload event one cycle", 32'(sc_event), 0);
    below[0] = 1'b0;
    en[0] = 1'b0;
    clr[0] = 1'b1;
    cyc();
    clr[0] = 1'b0;
  endtask

  task automatic t_disable();
    en[1] = 1'b0;
    cyc();
    check("R9 disable turns off", 32'(rail_on), 0);
    check("R9 disable no event", 32'(sc_event), 0);
  endtask

  task automatic t_shutdown();
    rise(1);
    rise(2);
    check("R2 rails 1 and 2 on", 32'(rail_on), 3'b110);
    shut = 1'b1;
    cyc();
    check("R10 all off", 32'(rail_on), 0);
    check("R10 no event", 32'(sc_event), 0);
    check("R10 gpo low", 32'(gpo_low), 1);
    shut = 1'b0;
    cyc();
    check("R10 gpo released", 32'(gpo_low), 0);
    check("R10 stays off after release", 32'(rail_on), 0);
    rise(2);
    check("R10 new enable after release", 32'(rail_on), 3'b100);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    t_reset();
    t_startup_short();
    t_fault_latch();
    t_overload();
    t_disable();
    t_shutdown();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule